// File: doc/BRIEF.md
# Rounding-Shift Butterfly Add/Sub Unit

This unit performs one fixed-point butterfly step. It takes two accumulator words, a signed double-width product and a shift count. It forms the accumulator-plus-product sum and the accumulator-minus-product difference in one pass. Each of these results is rounded to nearest, scaled down arithmetically by the shift count and sign-filled into one word. Both words come out together, one clock edge after the inputs are presented.

The product comes from a multiplier outside the block and arrives as a plain input. A shift count of zero takes a bypass path. That path returns the wrap-around word-width sum and difference of the accumulators and the low half of the product, with no rounding and no fill. For every other count, the work happens at double width. The rounded double-width value then supplies both the extracted field and the fill bit.

Top module: `bfly_rshift_unit`

## Requirements
- R1: While `rst_i` is high, `sum_o` and `diff_o` are cleared to zero at each rising clock edge.
- R2: The outputs are registered. Inputs present at a rising edge appear on `sum_o`/`diff_o` right after that edge, and the outputs hold until the next edge.
- R3: When the shift count is 0, `sum_o` = `acc_a_i + prod_i[XLEN-1:0]` and `diff_o` = `acc_b_i - prod_i[XLEN-1:0]`, both modulo 2^XLEN. Neither result is rounded or sign-filled.
- R4: When the shift count n is nonzero, each accumulator is sign-extended to 2*XLEN bits. The sum path adds the signed 2*XLEN-bit product and the difference path subtracts it.
- R5: For n nonzero, a single 1 is added at bit position n-1 (bit 0 is the LSB) of each 2*XLEN-bit intermediate before any shift. This rounds to nearest with ties going upward.
- R6: For n nonzero, each output field is bits n+XLEN-1 down to n of its rounded intermediate.
- R7: For n nonzero, every output bit at position n or above is ORed with bit 2*XLEN-1 of the rounded intermediate. The low n bits are the extracted field unchanged.
- R8: XLEN is a power of two and the shift port is log2(XLEN) bits wide. Every count from 0 to XLEN-1 is valid, including XLEN-1.
- R9: Carries out of the 2*XLEN-bit intermediate are dropped, so results wrap and never saturate. This includes the case where the rounding increment carries into the sign bit and flips it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| rst_i | input | 1 | Synchronous active-high reset |
| acc_a_i | input | XLEN | Signed accumulator for the sum path |
| acc_b_i | input | XLEN | Signed accumulator for the difference path |
| prod_i | input | 2*XLEN | Signed double-width product |
| shift_i | input | SHW | Unsigned rounding/scaling count n |
| sum_o | output | XLEN | Rounded, scaled sum result |
| diff_o | output | XLEN | Rounded, scaled difference result |

## Verification
The bench builds the unit with XLEN = 16, which makes the shift port 4 bits wide and the product 32 bits wide. At this width, expected values can be worked out by hand. The whole count range is reachable with few vectors: 0, 1, 2, 4, 8 and 15 = XLEN-1. Short operands are also enough to reach a negative product, negative accumulators, 2*XLEN-bit wrap-around and a rounding carry into the sign bit. The width-generic arithmetic is the same path that is used at XLEN = 64.

// File: rtl/bfly_pkg.sv
package bfly_pkg;

    // Operation a butterfly lane applies to the product
    typedef enum logic {
        LANE_ADD = 1'b0,
        LANE_SUB = 1'b1
    } lane_op_e;

endpackage

// File: rtl/bfly_widen.sv
// Sign-extends one accumulator and adds or subtracts the double-width product.
module bfly_widen
    import bfly_pkg::*;
#(
    parameter int       XLEN = 64,
    parameter lane_op_e OP   = LANE_ADD
) (
    input  logic [XLEN-1:0]   acc_i,
    input  logic [2*XLEN-1:0] prod_i,
    output logic [2*XLEN-1:0] wide_o
);
    localparam int W2 = 2 * XLEN;

    logic [W2-1:0] acc_ext;

    always_comb begin
        acc_ext = {{XLEN{acc_i[XLEN-1]}}, acc_i};
    end

    generate
        if (OP == LANE_ADD) begin : g_add
            always_comb wide_o = acc_ext + prod_i;
        end else begin : g_sub
            always_comb wide_o = acc_ext - prod_i;
        end
    endgenerate
endmodule

// File: rtl/bfly_round.sv
// Adds the round-to-nearest increment at bit n-1; nothing is added for n = 0.
module bfly_round #(
    parameter int XLEN = 64,
    parameter int SHW  = $clog2(XLEN)
) (
    input  logic [2*XLEN-1:0] wide_i,
    input  logic [SHW-1:0]    shift_i,
    output logic [2*XLEN-1:0] rnd_o
);
    localparam int W2 = 2 * XLEN;

    logic [W2-1:0]  incr;
    logic [SHW-1:0] pos;

    always_comb begin
        pos  = shift_i - SHW'(1);
        incr = (shift_i == '0) ? '0 : (W2'(1) << pos);
        rnd_o = wide_i + incr;
    end
endmodule

// File: rtl/bfly_shape.sv
// Extracts the scaled field, applies the sign fill, or bypasses for n = 0.
module bfly_shape #(
    parameter int XLEN = 64,
    parameter int SHW  = $clog2(XLEN)
) (
    input  logic [2*XLEN-1:0] rnd_i,
    input  logic [SHW-1:0]    shift_i,
    output logic [XLEN-1:0]   res_o
);
    localparam int W2 = 2 * XLEN;

    logic [W2-1:0]   shifted;
    logic [XLEN-1:0] field;
    logic [XLEN-1:0] low_mask;
    logic [XLEN-1:0] fill;
    logic            sign_bit;

    always_comb begin
        sign_bit = rnd_i[W2-1];
        shifted  = rnd_i >> shift_i;
        field    = shifted[XLEN-1:0];
        low_mask = (XLEN'(1) << shift_i) - XLEN'(1);
        fill     = {XLEN{sign_bit}} & ~low_mask;
        if (shift_i == '0) begin
            res_o = rnd_i[XLEN-1:0];
        end else begin
            res_o = field | fill;
        end
    end
endmodule

// File: rtl/bfly_rshift_unit.sv
module bfly_rshift_unit
    import bfly_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int SHW  = $clog2(XLEN)
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic [XLEN-1:0]     acc_a_i,
    input  logic [XLEN-1:0]     acc_b_i,
    input  logic [2*XLEN-1:0]   prod_i,
    input  logic [SHW-1:0]      shift_i,
    output logic [XLEN-1:0]     sum_o,
    output logic [XLEN-1:0]     diff_o
);
    localparam int W2     = 2 * XLEN;
    localparam int NLANES = 2;

    typedef struct packed {
        logic [XLEN-1:0] sum;
        logic [XLEN-1:0] diff;
        logic            live;
    } state_t;

    logic [XLEN-1:0] lane_acc [NLANES];
    logic [W2-1:0]   lane_wide[NLANES];
    logic [W2-1:0]   lane_rnd [NLANES];
    logic [XLEN-1:0] lane_res [NLANES];

    assign lane_acc[0] = acc_a_i;
    assign lane_acc[1] = acc_b_i;

    generate
        for (genvar g = 0; g < NLANES; g++) begin : g_lane
            localparam lane_op_e LOP = (g == 0) ? LANE_ADD : LANE_SUB;

            bfly_widen #(.XLEN(XLEN), .OP(LOP)) u_widen (
                .acc_i  (lane_acc[g]),
                .prod_i (prod_i),
                .wide_o (lane_wide[g])
            );

            bfly_round #(.XLEN(XLEN), .SHW(SHW)) u_round (
                .wide_i  (lane_wide[g]),
                .shift_i (shift_i),
                .rnd_o   (lane_rnd[g])
            );

            bfly_shape #(.XLEN(XLEN), .SHW(SHW)) u_shape (
                .rnd_i   (lane_rnd[g]),
                .shift_i (shift_i),
                .res_o   (lane_res[g])
            );
        end
    endgenerate

    state_t state_d, state_q;

    always_comb begin
        state_d      = state_q;
        state_d.sum  = lane_res[0];
        state_d.diff = lane_res[1];
        state_d.live = 1'b1;
        if (rst_i) begin
            state_d = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        state_q <= state_d;
    end

    assign sum_o  = state_q.sum;
    assign diff_o = state_q.diff;

    // R3
    bypass_sum_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q.live && $past(shift_i) == '0) |->
            (sum_o == $past(acc_a_i + prod_i[XLEN-1:0])));

    // R3
    bypass_diff_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q.live && $past(shift_i) == '0) |->
            (diff_o == $past(acc_b_i - prod_i[XLEN-1:0])));

    // R7
    sum_sign_fill_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q.live && $past(shift_i) != '0 && $past(lane_rnd[0][W2-1])) |->
            sum_o[XLEN-1]);

    // R7
    diff_sign_fill_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q.live && $past(shift_i) != '0 && $past(lane_rnd[1][W2-1])) |->
            diff_o[XLEN-1]);

    // R4
    sum_wide_low_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        lane_wide[0][XLEN-1:0] == acc_a_i + prod_i[XLEN-1:0]);

    // R4
    diff_wide_low_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        lane_wide[1][XLEN-1:0] == acc_b_i - prod_i[XLEN-1:0]);

    // R2
    hold_between_edges_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q.live && $past(state_q.live)) |-> $stable(sum_o) || ($past(lane_res[0]) == sum_o));
endmodule

// File: tb/bfly_rshift_unit_test.sv
module bfly_rshift_unit_test;
    localparam int XL  = 16;
    localparam int PW  = 2 * XL;
    localparam int SW  = $clog2(XL);
    localparam int NV  = 8;
    localparam int VW  = XL + XL + PW + SW + XL + XL;

    logic          clk = 1'b0;
    logic          rst;
    logic [XL-1:0] acc_a, acc_b;
    logic [PW-1:0] prod;
    logic [SW-1:0] shift;
    logic [XL-1:0] sum_o, diff_o;

    int checks   = 0;
    int failures = 0;

    always #2 clk = ~clk;

    bfly_rshift_unit #(.XLEN(XL)) uut (
        .clk_i   (clk),
        .rst_i   (rst),
        .acc_a_i (acc_a),
        .acc_b_i (acc_b),
        .prod_i  (prod),
        .shift_i (shift),
        .sum_o   (sum_o),
        .diff_o  (diff_o)
    );

    // {acc_a, acc_b, prod, n, expected sum, expected diff}
    localparam logic [VW-1:0] VEC [NV] = '{
        {16'h1234, 16'h1000, 32'h0000_0034, 4'd0,  16'h1268, 16'h0FCC}, // R3
        {16'h0001, 16'h0001, 32'hFFFF_8000, 4'd0,  16'h8001, 16'h8001}, // R3 negative product
        {16'h8000, 16'h7FFF, 32'hFFFF_FFFF, 4'd0,  16'h7FFF, 16'h8000}, // R3 wrap
        {16'h0003, 16'h0000, 32'h0000_0002, 4'd1,  16'h0003, 16'hFFFF}, // R5 n=1
        {16'h0000, 16'h0000, 32'h0001_2345, 4'd4,  16'h1234, 16'hFFFC}, // R6 R7
        {16'hFF00, 16'h8000, 32'h0000_0080, 4'd8,  16'h0000, 16'hFF80}, // R4 negative acc
        {16'h7FFF, 16'h8000, 32'h7FFF_FFFF, 4'd2,  16'hFFFC, 16'hE000}, // R9 wrap
        {16'h4000, 16'h0000, 32'h0000_4000, 4'd15, 16'h0001, 16'h0000}  // R8 R9 carry into sign
    };

    task automatic check(input string req, input logic [XL-1:0] got, input logic [XL-1:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic apply(input logic [XL-1:0] a, input logic [XL-1:0] b,
                         input logic [PW-1:0] p, input logic [SW-1:0] n);
        @(negedge clk);
        acc_a = a; acc_b = b; prod = p; shift = n;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #150000;
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; acc_a = 16'h1111; acc_b = 16'h2222; prod = 32'h3333_3333; shift = 4'd3;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset sum", sum_o, 16'h0000);
        check("R1 reset diff", diff_o, 16'h0000);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            logic [XL-1:0] va, vb, es, ed;
            logic [PW-1:0] vp;
            logic [SW-1:0] vn;
            {va, vb, vp, vn, es, ed} = VEC[i];
            apply(va, vb, vp, vn);
            check($sformatf("R3-R9 vector %0d sum", i), sum_o, es);
            check($sformatf("R3-R9 vector %0d diff", i), diff_o, ed);
        end

        // R5 tie on a negative value rounds upward: -1/2 -> 0, +1/2 -> 1
        apply(16'h0000, 16'h0000, 32'hFFFF_FFFF, 4'd1);
        check("R5 tie sum", sum_o, 16'h0000);
        check("R5 tie diff", diff_o, 16'h0001);

        // R2 outputs hold until the next rising edge
        @(negedge clk);
        acc_a = 16'h0100; acc_b = 16'h0200; prod = 32'h0000_0001; shift = 4'd0;
        #1;
        check("R2 hold sum", sum_o, 16'h0000);
        check("R2 hold diff", diff_o, 16'h0001);
        @(posedge clk);
        #1;
        check("R2 update sum", sum_o, 16'h0101);
        check("R2 update diff", diff_o, 16'h01FF);

        // R1 reset in mid-run clears the outputs
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R1 midrun sum", sum_o, 16'h0000);
        check("R1 midrun diff", diff_o, 16'h0000);
        @(negedge clk);
        rst = 1'b0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule